// File: doc/BRIEF.md
# Privilege-Aware Interrupt Priority Selector

This block holds one pending flag for each of seven processor interrupt classes and decides, every cycle and without registers on the path, which of them should be delivered. The decision depends on the current privilege state (hypervisor-privileged flag, interrupt enable, trap-level-zero enable, trap level), the processor interrupt level, a soft-interrupt register and bit 0 of a hypervisor interrupt-pending word. The order is not fixed. It changes with privilege mode and enable bits, and a pending device-vector interrupt sits between the low and high soft-interrupt levels.

Sources raise a class through a post port that carries a class index. The consumer sees a trap strobe with an encoded trap type, or a consume strobe when a vector is retired without a trap. It also sees the soft-interrupt level and an any-pending flag. When the consumer asserts `accept` while the block offers an outcome, the delivered class is cleared on that clock edge.

Top module: `intr_prio_sel`

## Requirements
- R1: While `rst_n` is low and after it is released, no class is pending: `any_pending`, `take_trap` and `consume` are 0.
- R2: A valid post sets the flag of that class. Posting a class that is already pending changes nothing. An internal count of pending classes always equals the number of set flags, and `any_pending` is 1 exactly when that count is nonzero.
- R3: A post with class index 7 changes no pending state and raises `post_error` in the same cycle.
- R4: When privileged with interrupts enabled, a pending hypervisor tick is trapped if `hintp0` is 1. Otherwise a pending interrupt vector is consumed: `consume`=1, `take_trap`=0.
- R5: When privileged with interrupts disabled, neither `take_trap` nor `consume` is raised, and no flag is cleared.
- R6: When not privileged, delivery is tried in this order: trap-level-zero, hypervisor tick (gated by `hintp0`), and then, only while `ie`=1, CPU mondo, device mondo, soft interrupt, resumable error. A class that is not deliverable passes the turn to the next one. At most one outcome is offered at a time.
- R7: Trap-level-zero is delivered only with `tlz_en`=1 and `trap_level`=0.
- R8: `soft_level` is the index of the highest set bit of `softint`, or 0 when none is set. When a soft interrupt has its turn, the level is below 6 and a vector is pending, the vector is consumed instead.
- R9: A soft interrupt is trapped only when `soft_level` > `pil`. On accept, its flag clears only if `softint` has no set bit left once the serviced level's bit is removed.
- R10: `accept` while an outcome is offered clears that class at the clock edge. Without `accept`, flags are held. A post to the same class in the same cycle wins, and the flag stays set.
- R11: `trap_type` encodes the class as 0 trap-level-zero, 1 hypervisor tick, 2 interrupt vector, 3 CPU mondo, 4 device mondo, 5 resumable error, 6 soft interrupt. It is 0 when `take_trap` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_valid | input | 1 | Post request |
| post_class | input | 3 | Class index to post (0..6 valid) |
| hpriv | input | 1 | Hypervisor-privileged mode |
| ie | input | 1 | Interrupt enable |
| tlz_en | input | 1 | Trap-level-zero enable |
| trap_level | input | TL_W | Current trap level |
| pil | input | LVL_W | Processor interrupt level |
| softint | input | SOFT_W | Soft-interrupt register |
| hintp0 | input | 1 | Bit 0 of hypervisor interrupt-pending |
| accept | input | 1 | Consumer takes the offered outcome |
| take_trap | output | 1 | A trap is offered |
| trap_type | output | 3 | Encoded class of the offered trap |
| consume | output | 1 | A vector is retired without a trap |
| soft_level | output | LVL_W | Highest set soft-interrupt bit |
| any_pending | output | 1 | At least one class pending |
| post_error | output | 1 | Current post carries an invalid index |

## Verification
The hardest situation to reach is the soft interrupt that stays pending after delivery, because `softint` still holds other bits. Close to it is the vector that is consumed only because a low soft level is pending and has its turn. Both need several classes pending at once, `ie` set, the mondo classes already drained and a chosen mix of `softint` bits and `pil`. The stimulus builds these states with directed sequences of posts and accepts. It then runs a long biased sweep whose `softint` values are one or two single-bit masks, so that levels and leftovers vary. A bench-side model of the pending flags predicts every outcome.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int NUM_CLS = 7;
  localparam int CLS_W   = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_TLZ    = 3'd0,
    CLS_HTICK  = 3'd1,
    CLS_IVEC   = 3'd2,
    CLS_CMONDO = 3'd3,
    CLS_DMONDO = 3'd4,
    CLS_RESERR = 3'd5,
    CLS_SOFT   = 3'd6
  } intr_class_e;
endpackage

// File: rtl/intr_soft_level.sv
module intr_soft_level #(
  parameter int SOFT_W = 16,
  localparam int LVL_W = $clog2(SOFT_W)
) (
  input  logic [SOFT_W-1:0] softint,
  output logic [LVL_W-1:0]  level,
  output logic              only_one
);
  logic [SOFT_W-1:0] lvl_bit;
  logic [SOFT_W-1:0] leftover;

  always_comb begin
    level = '0;
    for (int i = 0; i < SOFT_W; i++) begin
      if (softint[i]) level = i[LVL_W-1:0];
    end
  end

  always_comb begin
    lvl_bit  = {{(SOFT_W-1){1'b0}}, 1'b1} << level;
    leftover = softint & ~lvl_bit;
    only_one = (leftover == '0);
  end
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_pkg::*;
#(
  parameter int LVL_W   = 4,
  parameter int TL_W    = 3,
  parameter int VEC_LVL = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CLS-1:0] pend,
  input  logic               hpriv,
  input  logic               ie,
  input  logic               tlz_en,
  input  logic [TL_W-1:0]    trap_level,
  input  logic [LVL_W-1:0]   pil,
  input  logic [LVL_W-1:0]   level,
  input  logic               hintp0,
  output logic               take,
  output logic               cons,
  output intr_class_e        sel
);
  logic tlz_ok, htick_ok, vec_low;

  always_comb begin
    tlz_ok   = pend[CLS_TLZ] && tlz_en && (trap_level == '0);
    htick_ok = pend[CLS_HTICK] && hintp0;
    vec_low  = (level < LVL_W'(VEC_LVL)) && pend[CLS_IVEC];
  end

  always_comb begin
    take = 1'b0;
    cons = 1'b0;
    sel  = CLS_TLZ;
    if (hpriv) begin
      if (ie) begin
        if (htick_ok) begin
          take = 1'b1; sel = CLS_HTICK;
        end else if (pend[CLS_IVEC]) begin
          cons = 1'b1; sel = CLS_IVEC;
        end
      end
    end else begin
      if (tlz_ok) begin
        take = 1'b1; sel = CLS_TLZ;
      end else if (htick_ok) begin
        take = 1'b1; sel = CLS_HTICK;
      end else if (ie) begin
        if (pend[CLS_CMONDO]) begin
          take = 1'b1; sel = CLS_CMONDO;
        end else if (pend[CLS_DMONDO]) begin
          take = 1'b1; sel = CLS_DMONDO;
        end else if (pend[CLS_SOFT] && vec_low) begin
          cons = 1'b1; sel = CLS_IVEC;
        end else if (pend[CLS_SOFT] && (level > pil)) begin
          take = 1'b1; sel = CLS_SOFT;
        end else if (pend[CLS_RESERR]) begin
          take = 1'b1; sel = CLS_RESERR;
        end
      end
    end
  end

  AST_HPRIV_IE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hpriv && !ie) |-> (!take && !cons)); // R5
  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && cons)); // R6
  AST_TLZ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sel == CLS_TLZ) |-> (tlz_en && trap_level == '0)); // R7
  AST_SOFT_ABOVE_PIL: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sel == CLS_SOFT) |-> (level > pil)); // R9
  AST_CONSUME_IS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    cons |-> (sel == CLS_IVEC && pend[CLS_IVEC])); // R4
endmodule

// File: rtl/intr_pend_bank.sv
module intr_pend_bank
  import intr_pkg::*;
#(
  localparam int CNT_W = $clog2(NUM_CLS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               post_valid,
  input  logic [CLS_W-1:0]   post_class,
  input  logic               clr_valid,
  input  logic [CLS_W-1:0]   clr_class,
  output logic [NUM_CLS-1:0] pend,
  output logic               any_pending,
  output logic               post_error
);
  logic [NUM_CLS-1:0] set_vec, clr_vec, pend_next;
  logic [CNT_W-1:0]   cnt, cnt_next;
  logic               inc, dec, upd_en;

  always_comb begin
    post_error = post_valid && (post_class >= CLS_W'(NUM_CLS));
    set_vec = '0;
    clr_vec = '0;
    if (post_valid && !post_error) set_vec[post_class] = 1'b1;
    if (clr_valid && (clr_class < CLS_W'(NUM_CLS))) clr_vec[clr_class] = 1'b1;
    pend_next = (pend & ~clr_vec) | set_vec;
    inc       = |(set_vec & ~pend);
    dec       = |(clr_vec & pend & ~set_vec);
    cnt_next  = cnt + CNT_W'(inc) - CNT_W'(dec);
    upd_en    = (|set_vec) || (|clr_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      cnt  <= '0;
    end else if (upd_en) begin
      pend <= pend_next;
      cnt  <= cnt_next;
    end
  end

  assign any_pending = (cnt != '0);

  AST_COUNT_TRACKS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == CNT_W'($countones(pend))); // R2
  AST_BAD_POST_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && post_class >= CLS_W'(NUM_CLS) && !clr_valid) |=> $stable(pend)); // R3
  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && !(post_valid && post_class == clr_class)) |=> !pend[$past(clr_class)]); // R10
  AST_POST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && post_class < CLS_W'(NUM_CLS)) |=> pend[$past(post_class)]); // R2
endmodule

// File: rtl/intr_prio_sel.sv
module intr_prio_sel
  import intr_pkg::*;
#(
  parameter int SOFT_W  = 16,
  parameter int TL_W    = 3,
  parameter int VEC_LVL = 6,
  localparam int LVL_W  = $clog2(SOFT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post_valid,
  input  logic [2:0]        post_class,
  input  logic              hpriv,
  input  logic              ie,
  input  logic              tlz_en,
  input  logic [TL_W-1:0]   trap_level,
  input  logic [LVL_W-1:0]  pil,
  input  logic [SOFT_W-1:0] softint,
  input  logic              hintp0,
  input  logic              accept,
  output logic              take_trap,
  output logic [2:0]        trap_type,
  output logic              consume,
  output logic [LVL_W-1:0]  soft_level,
  output logic              any_pending,
  output logic              post_error
);
  logic [NUM_CLS-1:0] pend;
  logic               only_one;
  logic               take, cons, clr_valid;
  intr_class_e        sel;

  intr_soft_level #(.SOFT_W(SOFT_W)) u_lvl (
    .softint  (softint),
    .level    (soft_level),
    .only_one (only_one)
  );

  intr_arbiter #(.LVL_W(LVL_W), .TL_W(TL_W), .VEC_LVL(VEC_LVL)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend       (pend),
    .hpriv      (hpriv),
    .ie         (ie),
    .tlz_en     (tlz_en),
    .trap_level (trap_level),
    .pil        (pil),
    .level      (soft_level),
    .hintp0     (hintp0),
    .take       (take),
    .cons       (cons),
    .sel        (sel)
  );

  always_comb begin
    clr_valid = accept && (take || cons) && ((sel != CLS_SOFT) || only_one);
    take_trap = take;
    consume   = cons;
    trap_type = take ? sel : 3'd0;
  end

  intr_pend_bank u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .post_valid  (post_valid),
    .post_class  (post_class),
    .clr_valid   (clr_valid),
    .clr_class   (sel),
    .pend        (pend),
    .any_pending (any_pending),
    .post_error  (post_error)
  );

  AST_TRAP_TYPE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !take_trap |-> (trap_type == 3'd0)); // R11
  AST_NO_OFFER_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pending |-> (!take_trap && !consume)); // R1
endmodule

// File: tb/intr_prio_sel_test.sv
module intr_prio_sel_test;
  localparam int SOFT_W = 16;
  localparam int TL_W   = 3;
  localparam int LVL_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              post_valid;
  logic [2:0]        post_class;
  logic              hpriv, ie, tlz_en, hintp0, accept;
  logic [TL_W-1:0]   trap_level;
  logic [LVL_W-1:0]  pil;
  logic [SOFT_W-1:0] softint;
  logic              take_trap, consume, any_pending, post_error;
  logic [2:0]        trap_type;
  logic [LVL_W-1:0]  soft_level;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [6:0] m_pend;
  bit         e_take, e_cons;
  int         e_cls, e_lvl;

  always #2 clk = ~clk;

  intr_prio_sel #(.SOFT_W(SOFT_W), .TL_W(TL_W), .VEC_LVL(6)) uut (
    .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_class(post_class),
    .hpriv(hpriv), .ie(ie), .tlz_en(tlz_en), .trap_level(trap_level), .pil(pil),
    .softint(softint), .hintp0(hintp0), .accept(accept), .take_trap(take_trap),
    .trap_type(trap_type), .consume(consume), .soft_level(soft_level),
    .any_pending(any_pending), .post_error(post_error)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected outcome from the requirement text, using the bench's own flags.
  task automatic predict();
    bit tlz_ok, ht_ok;
    e_lvl = 0;
    for (int i = 0; i < SOFT_W; i++) if (softint[i]) e_lvl = i;
    e_take = 0; e_cons = 0; e_cls = 0;
    tlz_ok = m_pend[0] && tlz_en && (trap_level == 0);
    ht_ok  = m_pend[1] && hintp0;
    if (hpriv) begin
      if (ie) begin
        if (ht_ok) begin e_take = 1; e_cls = 1; end
        else if (m_pend[2]) begin e_cons = 1; e_cls = 2; end
      end
    end else if (tlz_ok) begin e_take = 1; e_cls = 0; end
    else if (ht_ok) begin e_take = 1; e_cls = 1; end
    else if (ie) begin
      if (m_pend[3]) begin e_take = 1; e_cls = 3; end
      else if (m_pend[4]) begin e_take = 1; e_cls = 4; end
      else if (m_pend[6] && e_lvl < 6 && m_pend[2]) begin e_cons = 1; e_cls = 2; end
      else if (m_pend[6] && e_lvl > int'(pil)) begin e_take = 1; e_cls = 6; end
      else if (m_pend[5]) begin e_take = 1; e_cls = 5; end
    end
  endtask

  // Check combinational outputs mid-cycle, then advance one edge and update the model.
  task automatic run_cycle(string tag);
    string t;
    bit clr;
    #1;
    predict();
    if (tag != "") t = tag;
    else if (hpriv && ie) t = "R4";
    else if (hpriv) t = "R5";
    else t = "R6";
    chk({t, " take_trap"}, int'(take_trap), int'(e_take));
    chk({t, " consume"},   int'(consume),   int'(e_cons));
    chk("R11 trap_type",   int'(trap_type), e_take ? e_cls : 0);
    chk("R8 soft_level",   int'(soft_level), e_lvl);
    chk("R2 any_pending",  int'(any_pending), int'(m_pend != 0));
    chk("R3 post_error",   int'(post_error), int'(post_valid && post_class == 3'd7));
    @(posedge clk);
    clr = accept && (e_take || e_cons) &&
          (e_cls != 6 || ((softint & ~(16'h1 << e_lvl)) == 0));
    if (clr) m_pend[e_cls] = 1'b0;
    if (post_valid && post_class != 3'd7) m_pend[post_class] = 1'b1;
    #1;
  endtask

  task automatic idle_inputs();
    post_valid = 0; post_class = 0; hpriv = 0; ie = 0; tlz_en = 0;
    trap_level = 0; pil = 0; softint = 0; hintp0 = 0; accept = 0;
  endtask

  task automatic post(int c);
    post_valid = 1; post_class = 3'(c);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    m_pend = '0;
    rst_n = 0;
    // R1: reset state, with stimulus that would otherwise be delivered
    post(3); ie = 1; accept = 1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 any_pending in reset", int'(any_pending), 0);
    chk("R1 take_trap in reset", int'(take_trap), 0);
    idle_inputs();
    rst_n = 1;
    run_cycle("R1");

    // R2: double post of the same class counts once
    post(5); run_cycle("R2");
    post(5); run_cycle("R2");
    post_valid = 0; ie = 1; accept = 1; run_cycle("R2");
    chk("R2 drained after one accept", int'(any_pending), 0);

    // R3: invalid index leaves nothing pending
    accept = 0; ie = 1; post(7); run_cycle("R3");
    post_valid = 0; run_cycle("R3");

    // R7: trap level nonzero blocks TLZ, then zero delivers
    post(0); run_cycle("R7");
    post_valid = 0; tlz_en = 1; trap_level = 3'd2; accept = 1; run_cycle("R7");
    trap_level = 0; tlz_en = 0; run_cycle("R7");
    tlz_en = 1; accept = 0; run_cycle("R7");
    // R10: post and accept of the same class in one cycle keep it pending
    accept = 1; post(0); run_cycle("R10");
    post_valid = 0; accept = 0; run_cycle("R10");
    accept = 1; run_cycle("R10");
    tlz_en = 0;

    // R4 / R5: privileged behaviour with tick and vector pending
    accept = 0; post(1); run_cycle("R4");
    post(2); run_cycle("R4");
    post_valid = 0; hpriv = 1; ie = 0; hintp0 = 1; accept = 1; run_cycle("R5");
    ie = 1; hintp0 = 0; run_cycle("R4");
    hintp0 = 1; run_cycle("R4");
    hpriv = 0; run_cycle("R4");

    // R8 / R9: soft interrupt with multiple levels, vector interplay
    accept = 0; hintp0 = 0; post(6); run_cycle("R9");
    post(2); run_cycle("R8");
    post_valid = 0; softint = 16'h0208; pil = 4'd2; accept = 1; run_cycle("R9");
    softint = 16'h0010; run_cycle("R8");
    run_cycle("R8");
    softint = 16'h0208; pil = 4'd9; run_cycle("R9");
    pil = 4'd2; run_cycle("R9");
    softint = 16'h0008; run_cycle("R9");
    run_cycle("R9");

    // Near-exhaustive biased sweep
    for (int n = 0; n < 6000; n++) begin
      post_valid = ($urandom % 2) == 0;
      post_class = 3'($urandom % 8);
      hpriv      = ($urandom % 4) == 0;
      ie         = ($urandom % 4) != 0;
      tlz_en     = ($urandom % 2) == 0;
      trap_level = (($urandom % 2) == 0) ? '0 : TL_W'($urandom);
      pil        = LVL_W'($urandom);
      softint    = (($urandom % 5) == 0) ? '0 :
                   ((16'h1 << ($urandom % 16)) |
                    ((($urandom % 2) == 0) ? (16'h1 << ($urandom % 16)) : 16'h0));
      hintp0     = ($urandom % 2) == 0;
      accept     = ($urandom % 5) < 3;
      run_cycle("");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule